// File: doc/BRIEF.md
# Cell Bus Receive Slave Port

This block is the receive half of a physical-layer slave that sits on a shared, multi-port cell bus. An internal source writes fixed-size cells into it one byte per clock. The block holds up to four whole cells. It hands them to the ATM-layer master that owns the bus, one byte per clock, in the order they were written.

The master polls each port by placing a 5-bit port address on the bus. This block drives its cell-available flag, together with an output enable for the external tri-state driver, only when the polled address equals its own programmed address. Address 31 is reserved as the null address and never matches. The master selects the port by holding the active-low enable high while it presents the matching address. Transfer starts in the next cycle in which it pulls the enable low. Each presented byte comes with an odd-parity bit, and the first byte of every cell comes with a start-of-cell flag.

Top module: `crx_slave_rx`

## Requirements
- R1: `clav_oe_o` is 1 exactly when `poll_addr_i` equals `my_addr_i` and `my_addr_i` is not 31. `clav_o` is 0 whenever `clav_oe_o` is 0.
- R2: While driven, `clav_o` is 1 if and only if at least one fully written cell is held whose first byte has not yet been transferred. A partly written cell is never advertised.
- R3: On a clock edge with `rx_enb_n_i` = 1, the port becomes selected if the address matches as in R1, and deselected otherwise. On an edge with `rx_enb_n_i` = 0, selection does not change.
- R4: While the port is selected and holds a cell, `rx_data_o` presents the current byte combinationally. The byte is consumed on each clock edge with `rx_enb_n_i` = 0, and the bytes of a cell appear in write order.
- R5: `rx_soc_o` is 1 only while byte 0 of a cell is presented.
- R6: `rx_par_o` always makes the 9 bits {`rx_par_o`, `rx_data_o`} have an odd number of ones.
- R7: If `rx_enb_n_i` is high in the middle of a cell, the current byte is held. The transfer resumes from that same byte when the enable returns low, even after a deselect and reselect.
- R8: Address 31 never selects the port. With `my_addr_i` = 31, driving the enable low consumes nothing.
- R9: The buffer holds at most 4 cells of 53 bytes each. A cell whose first byte arrives while 4 cells are held is discarded in full.
- R10: After reset the buffer is empty and the port is not selected: `rx_data_o` = 0, `rx_soc_o` = 0, `rx_par_o` = 1, and `clav_o` = 0.
- R11: When the port is not transferring (not selected, or empty), `rx_data_o` = 0 and `rx_soc_o` = 0.
- R12: Cells are delivered first-in first-out, and a cell may be written while another is being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running receive clock; every bus signal is timed to it |
| rst_ni | input | 1 | Active-low synchronous reset |
| my_addr_i | input | 5 | Programmed port address (31 disables the port) |
| poll_addr_i | input | 5 | Address driven by the master for polling and selection |
| rx_enb_n_i | input | 1 | Active-low enable from the master |
| rx_data_o | output | 8 | Cell byte presented to the master |
| rx_soc_o | output | 1 | Start-of-cell flag, high with byte 0 |
| rx_par_o | output | 1 | Odd parity over `rx_data_o` |
| clav_o | output | 1 | Cell-available flag |
| clav_oe_o | output | 1 | Output enable for the cell-available tri-state driver |
| wr_valid_i | input | 1 | Internal write strobe, one byte per cycle |
| wr_data_i | input | 8 | Internal write byte |

## Verification
The checker watches four things on every cycle. Selection must never move while the enable is low. A sample of the null address with the enable high must leave the port deselected. Start-of-cell must never repeat on consecutive consumed cycles. A stalled, still-addressed transfer must hold its byte steady. It also ties the available flag to a non-empty committed buffer and bounds the occupancy by the slot count.

Other properties need the bench's scenarios. These cover byte order and content across cells, the whole-cell drop on overflow, a partial cell staying hidden until its last byte, resuming after a deselect, and the null address consuming nothing. Each needs an expected byte stream that only a scenario can supply.

// File: rtl/crx_pkg.sv
package crx_pkg;

  localparam int unsigned PORT_AW  = 5;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [PORT_AW-1:0] NULL_PORT = '1;

  // odd parity: the returned bit plus the byte always hold an odd count of ones
  function automatic logic odd_parity(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction

  // a poll hits only on an exact match with a non-null programmed address
  function automatic logic addr_hit(input logic [PORT_AW-1:0] polled,
                                    input logic [PORT_AW-1:0] mine);
    return (polled == mine) && (mine != NULL_PORT);
  endfunction

endpackage

// File: rtl/crx_wr_ctrl.sv
module crx_wr_ctrl #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned CELL_SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(CELL_SLOTS),
  localparam int unsigned BIDX_W = $clog2(CELL_BYTES),
  localparam int unsigned CNT_W  = $clog2(CELL_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [CNT_W-1:0]  used_i,
  output logic              mem_we_o,
  output logic [SLOT_W-1:0] mem_slot_o,
  output logic [BIDX_W-1:0] mem_byte_o,
  output logic              commit_o
);

  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELL_SLOTS - 1);
  localparam logic [CNT_W-1:0]  SLOTS_C   = CNT_W'(CELL_SLOTS);

  logic [BIDX_W-1:0] byte_q;
  logic [SLOT_W-1:0] slot_q;
  logic              keep_q;
  logic              keep_now;

  // the keep/drop decision is taken once, at byte 0, and held for the cell
  assign keep_now   = (byte_q == '0) ? (used_i < SLOTS_C) : keep_q;
  assign mem_we_o   = wr_valid_i && keep_now;
  assign commit_o   = mem_we_o && (byte_q == LAST_BYTE);
  assign mem_slot_o = slot_q;
  assign mem_byte_o = byte_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      byte_q <= '0;
      slot_q <= '0;
      keep_q <= 1'b0;
    end else if (wr_valid_i) begin
      keep_q <= keep_now;
      byte_q <= (byte_q == LAST_BYTE) ? '0 : byte_q + 1'b1;
      if (commit_o) slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

endmodule

// File: rtl/crx_rd_ctrl.sv
module crx_rd_ctrl #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned CELL_SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(CELL_SLOTS),
  localparam int unsigned BIDX_W = $clog2(CELL_BYTES),
  localparam int unsigned CNT_W  = $clog2(CELL_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enb_n_i,
  input  logic              hit_i,
  input  logic [CNT_W-1:0]  used_i,
  output logic              sel_o,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIDX_W-1:0] byte_o,
  output logic              release_o
);

  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELL_SLOTS - 1);

  logic              sel_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIDX_W-1:0] byte_q;
  logic              take;

  assign busy_o    = sel_q && (used_i != '0);
  assign take      = busy_o && !enb_n_i;
  assign release_o = take && (byte_q == LAST_BYTE);
  assign sel_o     = sel_q;
  assign slot_o    = slot_q;
  assign byte_o    = byte_q;

  // selection is resolved only on cycles where the enable is high
  always_ff @(posedge clk_i) begin
    if (!rst_ni)      sel_q <= 1'b0;
    else if (enb_n_i) sel_q <= hit_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      slot_q <= '0;
      byte_q <= '0;
    end else if (take) begin
      byte_q <= (byte_q == LAST_BYTE) ? '0 : byte_q + 1'b1;
      if (release_o) slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

endmodule

// File: rtl/crx_buffer.sv
module crx_buffer #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned CELL_SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(CELL_SLOTS),
  localparam int unsigned BIDX_W = $clog2(CELL_BYTES),
  localparam int unsigned WORDS  = CELL_BYTES * CELL_SLOTS,
  localparam int unsigned MEM_AW = $clog2(WORDS)
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [SLOT_W-1:0]         wslot_i,
  input  logic [BIDX_W-1:0]         wbyte_i,
  input  logic [crx_pkg::BYTE_W-1:0] wdata_i,
  input  logic [SLOT_W-1:0]         rslot_i,
  input  logic [BIDX_W-1:0]         rbyte_i,
  output logic [crx_pkg::BYTE_W-1:0] rdata_o
);

  logic [crx_pkg::BYTE_W-1:0] mem_q [WORDS];
  logic [MEM_AW-1:0] waddr;
  logic [MEM_AW-1:0] raddr;

  assign waddr   = MEM_AW'(wslot_i) * MEM_AW'(CELL_BYTES) + MEM_AW'(wbyte_i);
  assign raddr   = MEM_AW'(rslot_i) * MEM_AW'(CELL_BYTES) + MEM_AW'(rbyte_i);
  assign rdata_o = mem_q[raddr];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr] <= wdata_i;
  end

endmodule

// File: rtl/crx_slave_rx.sv
module crx_slave_rx #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned CELL_SLOTS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [crx_pkg::PORT_AW-1:0] my_addr_i,
  input  logic [crx_pkg::PORT_AW-1:0] poll_addr_i,
  input  logic                        rx_enb_n_i,
  output logic [crx_pkg::BYTE_W-1:0]  rx_data_o,
  output logic                        rx_soc_o,
  output logic                        rx_par_o,
  output logic                        clav_o,
  output logic                        clav_oe_o,
  input  logic                        wr_valid_i,
  input  logic [crx_pkg::BYTE_W-1:0]  wr_data_i
);

  localparam int unsigned SLOT_W = $clog2(CELL_SLOTS);
  localparam int unsigned BIDX_W = $clog2(CELL_BYTES);
  localparam int unsigned CNT_W  = $clog2(CELL_SLOTS + 1);

  // named internal events, visible to the bound checker
  logic [CNT_W-1:0]          used_cnt;
  logic [CNT_W-1:0]          ready_cnt;
  logic                      wr_commit;
  logic                      rd_release;
  logic                      addr_hit;
  logic                      sel_q;
  logic                      rd_busy;
  logic                      mem_we;
  logic [SLOT_W-1:0]         w_slot;
  logic [BIDX_W-1:0]         w_byte;
  logic [SLOT_W-1:0]         r_slot;
  logic [BIDX_W-1:0]         r_byte;
  logic [crx_pkg::BYTE_W-1:0] r_data;

  assign addr_hit = crx_pkg::addr_hit(poll_addr_i, my_addr_i);

  crx_wr_ctrl #(.CELL_BYTES(CELL_BYTES), .CELL_SLOTS(CELL_SLOTS)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .used_i     (used_cnt),
    .mem_we_o   (mem_we),
    .mem_slot_o (w_slot),
    .mem_byte_o (w_byte),
    .commit_o   (wr_commit)
  );

  crx_rd_ctrl #(.CELL_BYTES(CELL_BYTES), .CELL_SLOTS(CELL_SLOTS)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enb_n_i   (rx_enb_n_i),
    .hit_i     (addr_hit),
    .used_i    (used_cnt),
    .sel_o     (sel_q),
    .busy_o    (rd_busy),
    .slot_o    (r_slot),
    .byte_o    (r_byte),
    .release_o (rd_release)
  );

  crx_buffer #(.CELL_BYTES(CELL_BYTES), .CELL_SLOTS(CELL_SLOTS)) u_buf (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .wslot_i (w_slot),
    .wbyte_i (w_byte),
    .wdata_i (wr_data_i),
    .rslot_i (r_slot),
    .rbyte_i (r_byte),
    .rdata_o (r_data)
  );

  // committed cells not yet fully read
  always_ff @(posedge clk_i) begin
    if (!rst_ni) used_cnt <= '0;
    else         used_cnt <= used_cnt + CNT_W'(wr_commit) - CNT_W'(rd_release);
  end

  // a cell whose read-out has begun is no longer advertised
  assign ready_cnt = used_cnt - CNT_W'(r_byte != '0);

  assign clav_oe_o = addr_hit;
  assign clav_o    = addr_hit && (ready_cnt != '0);
  assign rx_data_o = rd_busy ? r_data : '0;
  assign rx_soc_o  = rd_busy && (r_byte == '0);
  assign rx_par_o  = crx_pkg::odd_parity(rx_data_o);

endmodule

// File: rtl/crx_slave_rx_chk.sv
module crx_slave_rx_chk #(
  parameter int unsigned CELL_SLOTS = 4,
  localparam int unsigned CNT_W = $clog2(CELL_SLOTS + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [crx_pkg::PORT_AW-1:0] poll_addr_i,
  input logic                        rx_enb_n_i,
  input logic [crx_pkg::BYTE_W-1:0]  rx_data_o,
  input logic                        rx_soc_o,
  input logic                        clav_o,
  input logic                        clav_oe_o,
  input logic                        sel_q,
  input logic                        rd_busy,
  input logic [CNT_W-1:0]            used_cnt
);

  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(CELL_SLOTS);

  // R3
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_enb_n_i |=> $stable(sel_q));

  // R8
  null_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_enb_n_i && poll_addr_i == crx_pkg::NULL_PORT) |=> !sel_q);

  // R1
  clav_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clav_oe_o |-> !clav_o);

  // R2
  clav_whole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clav_o |-> (used_cnt != '0));

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_cnt <= SLOTS_C);

  // R5
  soc_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_soc_o && !rx_enb_n_i) |=> !rx_soc_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_busy && rx_enb_n_i && clav_oe_o) |=> ($stable(rx_data_o) && $stable(rx_soc_o)));

endmodule

bind crx_slave_rx crx_slave_rx_chk #(.CELL_SLOTS(CELL_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .poll_addr_i (poll_addr_i),
  .rx_enb_n_i  (rx_enb_n_i),
  .rx_data_o   (rx_data_o),
  .rx_soc_o    (rx_soc_o),
  .clav_o      (clav_o),
  .clav_oe_o   (clav_oe_o),
  .sel_q       (sel_q),
  .rd_busy     (rd_busy),
  .used_cnt    (used_cnt)
);

// File: tb/crx_slave_rx_bench.sv
module crx_slave_rx_bench;

  localparam int CLK_T = 10;
  localparam int NB    = 53;
  localparam logic [4:0] MY    = 5'd5;
  localparam logic [4:0] OTHER = 5'd9;
  // poll address, expected output enable
  localparam logic [5:0] POLL_TAB [6] = '{
    {5'd5, 1'b1}, {5'd4, 1'b0}, {5'd31, 1'b0},
    {5'd6, 1'b0}, {5'd0, 1'b0}, {5'd5, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] my_addr = MY;
  logic [4:0] poll = MY;
  logic       enb_n = 1'b1;
  logic [7:0] rx_data;
  logic       rx_soc, rx_par, clav, clav_oe;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  int checks = 0;
  int errors = 0;

  always #(CLK_T/2) clk = ~clk;

  crx_slave_rx u_crx_slave_rx (
    .clk_i(clk), .rst_ni(rst_n), .my_addr_i(my_addr), .poll_addr_i(poll),
    .rx_enb_n_i(enb_n), .rx_data_o(rx_data), .rx_soc_o(rx_soc), .rx_par_o(rx_par),
    .clav_o(clav), .clav_oe_o(clav_oe), .wr_valid_i(wr_valid), .wr_data_i(wr_data)
  );

  function automatic logic [7:0] pat(input int id, input int b);
    return 8'((id * 37 + b * 3 + 1) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_bytes(input int id, input int from, input int upto);
    for (int b = from; b <= upto; b++) begin
      @(negedge clk); wr_valid = 1'b1; wr_data = pat(id, b);
    end
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic write_cell(input int id);
    write_bytes(id, 0, NB - 1);
  endtask

  // stall_at < 0: no stall; desel: deselect and reselect during the stall
  task automatic read_cell(input int id, input int stall_at, input bit desel);
    @(negedge clk); poll = MY; enb_n = 1'b1;
    @(negedge clk); enb_n = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (b == stall_at) begin
        enb_n = 1'b1; #1;
        chk("R7 stall first", rx_data, pat(id, b));
        @(negedge clk); #1;
        chk("R7 stall held", rx_data, pat(id, b));
        if (desel) begin
          poll = OTHER;
          @(negedge clk); #1;
          chk("R11 deselected data", rx_data, 0);
          chk("R11 deselected soc", rx_soc, 0);
          poll = MY;
          @(negedge clk);
        end
        enb_n = 1'b0;
      end
      #1;
      chk("R4 data", rx_data, pat(id, b));
      chk("R5 soc", rx_soc, (b == 0));
      chk("R6 parity", rx_par, ~^pat(id, b));
      @(negedge clk);
    end
    enb_n = 1'b1;
  endtask

  initial begin
    #(CLK_T * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 data", rx_data, 0);
    chk("R10 soc", rx_soc, 0);
    chk("R10 parity", rx_par, 1);
    chk("R10 clav", clav, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 clav after reset", clav, 0);
    chk("R1 oe on match", clav_oe, 1);

    // table of polls with one whole cell held
    write_cell(1);
    foreach (POLL_TAB[i]) begin
      @(negedge clk); poll = POLL_TAB[i][5:1]; enb_n = 1'b1; #1;
      chk("R1 clav_oe", clav_oe, POLL_TAB[i][0]);
      chk("R2 clav", clav, POLL_TAB[i][0]);
    end

    // R4 R5 R6 R7 with a stall plus deselect at byte 20
    read_cell(1, 20, 1'b1);
    #1; chk("R2 empty after read", clav, 0);

    // R2 partial cell stays hidden
    write_bytes(2, 0, NB - 2);
    #1; chk("R2 partial hidden", clav, 0);
    write_bytes(2, NB - 1, NB - 1);
    #1; chk("R2 whole shown", clav, 1);
    read_cell(2, 0, 1'b0);

    // R9 overflow: fifth cell dropped whole; R12 order
    for (int c = 0; c < 5; c++) write_cell(10 + c);
    #1; chk("R9 clav full", clav, 1);
    for (int c = 0; c < 4; c++) read_cell(10 + c, -1, 1'b0);
    #1; chk("R9 fifth cell dropped", clav, 0);

    // R12 concurrent write and read
    write_cell(20);
    fork
      read_cell(20, -1, 1'b0);
      write_cell(21);
    join
    read_cell(21, 52, 1'b0);
    #1; chk("R12 empty", clav, 0);

    // R8 null address consumes nothing
    write_cell(30);
    @(negedge clk); my_addr = 5'd31; poll = 5'd31; enb_n = 1'b1; #1;
    chk("R8 oe off", clav_oe, 0);
    chk("R1 clav low when floating", clav, 0);
    @(negedge clk); enb_n = 1'b0;
    repeat (3) begin
      #1; chk("R8 no data", rx_data, 0);
      chk("R8 no soc", rx_soc, 0);
      @(negedge clk);
    end
    enb_n = 1'b1; my_addr = MY;
    read_cell(30, -1, 1'b0);

    // R3 mismatched address never selects
    write_cell(31);
    @(negedge clk); poll = OTHER; enb_n = 1'b1;
    @(negedge clk); enb_n = 1'b0;
    repeat (3) begin
      #1; chk("R3 unselected data", rx_data, 0);
      chk("R11 unselected soc", rx_soc, 0);
      @(negedge clk);
    end
    enb_n = 1'b1;
    read_cell(31, -1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule